// File: doc/BRIEF.md
# Pulse Repetition-Rate Gate

This block passes a pulse train from its input to its output only when the pulses are spaced far enough apart. A retriggerable one-shot timer starts again on every rising edge of the input. If the timer runs for its whole period and the input is still high when it ends, a gate flag is set. The flag is cleared as soon as the input drops. The output is the synchronised input ANDed with the flag. A slow train with wide pulses therefore appears at the output, each pulse cut short at its start by the timer period. A fast train keeps restarting the timer, so the timer never completes and the output stays low.

The input is asynchronous and first passes through a flip-flop synchroniser. The timer period `THRESH` is given in clock cycles. For example, a 1 ms limit at a 1 MHz clock is `THRESH = 1000`. Clearing the flag has priority over setting it, so the flag is always out of its cleared state before a set can take effect.

The gate flag is kept by a three-state machine:
- `ST_LOW`: the input is low and the flag is clear.
- `ST_ARMED`: the input is high and the timer is running.
- `ST_OPEN`: the flag is set.

The machine has three transitions:
- `T_RISE` (`ST_LOW` to `ST_ARMED`) is taken on a synchronised rising edge.
- `T_EXPIRE` (`ST_ARMED` to `ST_OPEN`) is taken when the timer completes while the input is high.
- `T_DROP` (`ST_ARMED` or `ST_OPEN` to `ST_LOW`) is taken whenever the synchronised input is low.

Top module: `rg_rate_gate`

## Requirements
- R1: While `rst_ni` is low, `pass_o` is 0. After reset is released with `pulse_i` held high, the gate qualifies again exactly as for a fresh rising edge.
- R2: `pulse_i` is seen through a 2-stage synchroniser. `pass_o` falls exactly 2 clock edges after `pulse_i` falls.
- R3: The timer completes exactly `THRESH` cycles after the last synchronised rising edge. With `pulse_i` held high, `pass_o` rises exactly `THRESH`+3 clock edges after `pulse_i` rises.
- R4: A new rising edge before completion restarts the full `THRESH` period.
- R5: If rising edges come `THRESH` cycles apart or closer, the timer never completes and `pass_o` stays 0.
- R6: The flag is cleared whenever the synchronised input is low. A timer completion while the input is low has no effect, so pulses no wider than `THRESH` cycles produce no output.
- R7: Once the flag is set, `pass_o` follows the input. An isolated pulse of width W cycles gives max(0, W-`THRESH`-1) high cycles on `pass_o`.
- R8: When the timer completes in the same cycle that the synchronised input is low, the clear wins. A pulse that follows immediately is not passed.
- R9: `pass_o` is never high while the synchronised input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Asynchronous pulse train |
| pass_o | output | 1 | Gated pulse train |

## Verification
The bench builds the gate with `THRESH = 6` and the default two synchroniser stages. This keeps the timer period short, so these cases fit in a few dozen cycles each:
- the exact completion edge;
- the boundary pulse widths `THRESH`+1 and `THRESH`+2;
- trains spaced exactly at the threshold;
- a completion that lands on the first low cycle.

The short period also lets a retriggered pulse be told apart from one timed from the first edge, because the two differ by only a few cycles.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        ST_LOW   = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o
);
    localparam int LAST = STAGES;

    logic [LAST:1] taps;
    logic          prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            taps <= '0;
        end else begin
            taps[1] <= d_i;
            for (int i = 2; i <= LAST; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= taps[LAST];
    end

    assign lvl_o  = taps[LAST];
    assign rise_o = taps[LAST] & ~prev_q;
endmodule

// File: rtl/rg_oneshot.sv
module rg_oneshot #(
    parameter int THRESH = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic expire_o
);
    localparam int             CW    = $clog2(THRESH + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(THRESH);
    localparam logic [CW-1:0]  ONE   = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // A trigger in the completion cycle restarts the timer instead.
    assign expire_o = run_q & (cnt_q == LIMIT) & ~trig_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (trig_i) begin
            cnt_q <= ONE;
            run_q <= 1'b1;
        end else if (expire_o) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/rg_gate_fsm.sv
module rg_gate_fsm
    import rg_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        lvl_i,
    input  logic        rise_i,
    input  logic        expire_i,
    output logic        flag_o,
    output gate_state_e state_o
);
    gate_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LOW;
        else         state_q <= state_d;
    end

    // Next state: T_DROP is tested first so that clearing beats setting.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (rise_i) state_d = ST_ARMED;          // T_RISE
            end
            ST_ARMED: begin
                if (!lvl_i)        state_d = ST_LOW;     // T_DROP
                else if (expire_i) state_d = ST_OPEN;    // T_EXPIRE
            end
            ST_OPEN: begin
                if (!lvl_i) state_d = ST_LOW;            // T_DROP
            end
            default: state_d = ST_LOW;
        endcase
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == ST_OPEN);
    end

    assign state_o = state_q;
endmodule

// File: rtl/rg_rate_gate.sv
module rg_rate_gate
    import rg_pkg::*;
#(
    parameter int THRESH      = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    output logic pass_o
);
    logic        sync_lvl;
    logic        sync_rise;
    logic        os_expire;
    logic        gate_flag;
    gate_state_e fsm_state;

    rg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pulse_i),
        .lvl_o  (sync_lvl),
        .rise_o (sync_rise)
    );

    rg_oneshot #(.THRESH(THRESH)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_i   (sync_rise),
        .expire_o (os_expire)
    );

    rg_gate_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (sync_lvl),
        .rise_i   (sync_rise),
        .expire_i (os_expire),
        .flag_o   (gate_flag),
        .state_o  (fsm_state)
    );

    assign pass_o = gate_flag & sync_lvl;
endmodule

// File: rtl/rg_rate_gate_chk.sv
module rg_rate_gate_chk
    import rg_pkg::*;
#(
    parameter int THRESH = 1000
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        lvl_i,
    input logic        rise_i,
    input logic        expire_i,
    input gate_state_e state_i,
    input logic        pass_i
);
    localparam int SW = $clog2(THRESH + 2) + 1;
    localparam logic [SW-1:0] SMAX = {SW{1'b1}};

    // Cycles since the last rising edge, saturating.
    logic [SW-1:0] since_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           since_q <= SMAX;
        else if (rise_i)       since_q <= SW'(1);
        else if (since_q != SMAX) since_q <= since_q + SW'(1);
    end

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            p_reset_quiet_r1: assert (!pass_i);
        end
    end

    p_expire_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |-> (since_q == SW'(THRESH)));

    p_open_after_expiry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state_i == ST_OPEN) |-> $past(expire_i));

    p_rise_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> !expire_i);

    p_drop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lvl_i |=> (state_i != ST_OPEN));

    p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_i && !lvl_i) |=> (state_i == ST_LOW));

    p_out_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_i |-> lvl_i);
endmodule

bind rg_rate_gate rg_rate_gate_chk #(.THRESH(THRESH)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (sync_lvl),
    .rise_i   (sync_rise),
    .expire_i (os_expire),
    .state_i  (fsm_state),
    .pass_i   (pass_o)
);

// File: tb/rg_rate_gate_tb_top.sv
`timescale 1ns/1ps
module rg_rate_gate_tb_top;
    localparam int TH = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse = 1'b0;
    logic pass;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rg_rate_gate #(.THRESH(TH), .SYNC_STAGES(2)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .pulse_i (pulse),
        .pass_o  (pass)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One pulse of width w then low for l cycles; returns high cycles seen.
    task automatic pulse_run(input int w, input int l, output int cnt);
        cnt = 0;
        pulse = 1'b1;
        for (int i = 0; i < w; i++) begin
            tick(1);
            cnt += int'(pass);
        end
        pulse = 1'b0;
        for (int i = 0; i < l; i++) begin
            tick(1);
            cnt += int'(pass);
        end
    endtask

    task automatic settle();
        pulse = 1'b0;
        tick(TH + 6);
    endtask

    task automatic t_reset();
        check("R1 output low in reset", int'(pass), 0);
        rst_n = 1'b1;
        tick(2);
        check("R1 output low after release", int'(pass), 0);
    endtask

    task automatic t_latency();
        pulse = 1'b1;
        tick(TH + 2);
        check("R3 not yet open at THRESH+2", int'(pass), 0);
        tick(1);
        check("R3 open at THRESH+3", int'(pass), 1);
        tick(5);
        check("R7 follows while high", int'(pass), 1);
        pulse = 1'b0;
        tick(1);
        check("R2 still high one edge after fall", int'(pass), 1);
        tick(1);
        check("R2 low two edges after fall", int'(pass), 0);
        settle();
    endtask

    task automatic t_widths();
        int c;
        pulse_run(TH + 1, 4, c);
        check("R7 width THRESH+1 gives 0", c, 0);
        settle();
        pulse_run(TH + 2, 4, c);
        check("R7 width THRESH+2 gives 1", c, 1);
        settle();
        pulse_run(TH + 9, 4, c);
        check("R7 width THRESH+9 gives 8", c, 8);
        settle();
    endtask

    task automatic t_short_pulses();
        int c, tot;
        tot = 0;
        for (int k = 0; k < 4; k++) begin
            pulse_run(3, TH + 8, c);
            tot += c;
        end
        check("R6 short slow pulses blocked", tot, 0);
        pulse_run(TH, TH + 4, c);
        check("R6 width THRESH blocked", c, 0);
        settle();
    endtask

    task automatic t_fast_train();
        int c, tot;
        tot = 0;
        for (int k = 0; k < 10; k++) begin
            pulse_run(TH - 1, 1, c);
            tot += c;
        end
        check("R5 period THRESH never passes", tot, 0);
        tot = 0;
        for (int k = 0; k < 10; k++) begin
            pulse_run(2, 1, c);
            tot += c;
        end
        check("R5 fast train never passes", tot, 0);
        settle();
    endtask

    task automatic t_retrigger();
        int c;
        pulse_run(4, 1, c);
        pulse = 1'b1;
        tick(TH + 2);
        c += int'(pass);
        check("R4 restart: low at THRESH+2 after second edge", c, 0);
        tick(1);
        check("R4 restart: open at THRESH+3 after second edge", int'(pass), 1);
        settle();
    endtask

    task automatic t_clear_wins();
        int c1, c2;
        pulse_run(TH, 1, c1);
        pulse_run(3, TH + 4, c2);
        check("R8 clear beats set", c1 + c2, 0);
        settle();
    endtask

    task automatic t_reset_mid();
        pulse = 1'b1;
        tick(TH + 5);
        check("R7 open before reset", int'(pass), 1);
        rst_n = 1'b0;
        #1;
        check("R1 reset forces low", int'(pass), 0);
        tick(2);
        rst_n = 1'b1;
        tick(TH + 2);
        check("R1 not open at THRESH+2 after release", int'(pass), 0);
        tick(1);
        check("R1 reopen at THRESH+3 after release", int'(pass), 1);
        settle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        tick(3);
        t_reset();
        t_latency();
        t_widths();
        t_short_pulses();
        t_fast_train();
        t_retrigger();
        t_clear_wins();
        t_reset_mid();
        finish_run();
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule